// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent page mappings so that a 32-bit virtual address can be turned into a physical address in the same cycle it is presented. Pages are 4 KB. The upper 20 bits of the virtual address (the page number) are compared against every stored entry at once. The lower 12 bits pass through unchanged. Each entry carries its own read and write permission. A lookup that the permissions do not allow is flagged as a protection fault and leaves no trace in the entry's status.

When a lookup misses, the surrounding logic fetches the mapping and writes it in through the refill port. The block picks the slot itself, using each entry's valid bit and reference bit. Each entry also keeps a dirty bit, which a permitted write sets. The lookup reports the dirty bit so that a later replacement can decide whether a write-back is needed. A single flush input empties the whole cache.

Top module: `xl_tlb`

## Requirements
- R1: When `lk_req` is 1 and a valid entry holds the page number `lk_vaddr[31:12]`, `lk_hit` is 1 in the same cycle. In that case `lk_paddr` equals the entry's physical page number in bits 31:12 and `lk_vaddr[11:0]` in bits 11:0.
- R2: With no such entry, or with `lk_req` at 0, `lk_hit`, `lk_fault`, `lk_dirty` and `lk_paddr` are all 0.
- R3: A hit with `lk_write`=1 on an entry without write permission, or with `lk_write`=0 on an entry without read permission, sets `lk_fault` to 1 while `lk_hit` stays 1. A faulting access changes neither the dirty bit nor the reference bit.
- R4: A permitted write hit sets the entry's dirty bit. `lk_dirty` shows the stored dirty bit of the hit entry, as it was before the current access. A refill writes the dirty bit as 0.
- R5: A permitted hit sets the entry's reference bit. A refill writes the reference bit as 0.
- R6: A refill whose page number is not present goes to the lowest-index invalid entry.
- R7: When all entries are valid, a refill goes to the lowest-index entry whose reference bit is 0.
- R8: When all entries are valid and every reference bit is 1, a refill goes to entry 0 and every reference bit is cleared. A permitted lookup hit in that same cycle still sets its own entry's reference bit.
- R9: A refill of a page number already present overwrites that entry, so that no page number is ever held twice.
- R10: `flush_all` clears every valid, dirty and reference bit in one cycle. It overrides a refill in the same cycle.
- R11: A lookup in the same cycle as a refill sees the contents from before the refill.
- R12: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| lk_hit | output | 1 | A valid entry matches the page number |
| lk_paddr | output | 32 | Translated physical address, 0 on a miss |
| lk_fault | output | 1 | Hit whose access type is not permitted |
| lk_dirty | output | 1 | Stored dirty bit of the hit entry |
| rf_req | input | 1 | Write a new mapping |
| rf_vpn | input | 20 | Virtual page number of the new mapping |
| rf_ppn | input | 20 | Physical page number of the new mapping |
| rf_rd_ok | input | 1 | Read permission of the new mapping |
| rf_wr_ok | input | 1 | Write permission of the new mapping |
| flush_all | input | 1 | Invalidate every entry |

## Verification
A lookup and a refill can occur in the same cycle. They may target the same page number, or the refill may be the one that clears all reference bits while the lookup sets one. The bench provokes these collisions with directed cases and with random traffic over a small page-number pool, where lookups and refills often collide. It judges each collision against a bench model that evaluates the lookup on the old contents and then applies the refill, the reference clear and the lookup's own updates in the required order. A flush arriving together with a refill is checked the same way, by looking up both page numbers afterwards.

// File: rtl/xl_pkg.sv
package xl_pkg;
  parameter int unsigned XL_OFF_W = 12;
  parameter int unsigned XL_VPN_W = 20;
  parameter int unsigned XL_PPN_W = 20;
  parameter int unsigned XL_VA_W  = XL_VPN_W + XL_OFF_W;
  parameter int unsigned XL_PA_W  = XL_PPN_W + XL_OFF_W;

  typedef struct packed {
    logic [XL_VPN_W-1:0] vpn;
    logic [XL_PPN_W-1:0] ppn;
    logic                rd_ok;
    logic                wr_ok;
  } xl_map_t;

  typedef enum logic [1:0] {
    PICK_MATCH = 2'd0,
    PICK_FREE  = 2'd1,
    PICK_COLD  = 2'd2,
    PICK_WRAP  = 2'd3
  } xl_pick_t;
endpackage

// File: rtl/xl_entry.sv
module xl_entry
  import xl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    load,
  input  logic    clr_ref,
  input  logic    touch,
  input  logic    wtouch,
  input  xl_map_t map_in,
  output logic    live_q,
  output logic    dirty_q,
  output logic    refd_q,
  output xl_map_t map_q
);
  logic live_d;
  logic dirty_d;
  logic refd_d;

  always_comb begin
    live_d  = live_q;
    dirty_d = dirty_q;
    refd_d  = refd_q;
    if (flush) begin
      live_d  = 1'b0;
      dirty_d = 1'b0;
      refd_d  = 1'b0;
    end else if (load) begin
      live_d  = 1'b1;
      dirty_d = 1'b0;
      refd_d  = 1'b0;
    end else begin
      refd_d  = (refd_q & ~clr_ref) | touch;
      dirty_d = dirty_q | wtouch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      dirty_q <= 1'b0;
      refd_q  <= 1'b0;
    end else begin
      live_q  <= live_d;
      dirty_q <= dirty_d;
      refd_q  <= refd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      map_q <= map_in;
    end
  end

  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wtouch && !flush && !load) |=> dirty_q); // R4
  AST_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !flush && !load) |=> refd_q); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!live_q && !dirty_q && !refd_q)); // R10
endmodule

// File: rtl/xl_match.sv
module xl_match #(
  parameter int unsigned N     = 64,
  parameter int unsigned W     = 20,
  localparam int unsigned IDXW = $clog2(N)
) (
  input  logic [N-1:0]        live,
  input  logic [N-1:0][W-1:0] keys,
  input  logic [W-1:0]        probe,
  output logic                hit,
  output logic [N-1:0]        vec,
  output logic [IDXW-1:0]     idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec[g] = live[g] && (keys[g] == probe);
  end

  assign hit = |vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/xl_victim.sv
module xl_victim
  import xl_pkg::*;
#(
  parameter int unsigned N     = 64,
  localparam int unsigned IDXW = $clog2(N)
) (
  input  logic [N-1:0]    live,
  input  logic [N-1:0]    refd,
  input  logic            dup_hit,
  input  logic [IDXW-1:0] dup_idx,
  output logic [IDXW-1:0] idx,
  output logic            clr_all
);
  logic [IDXW-1:0] free_idx;
  logic [IDXW-1:0] cold_idx;
  logic            any_free;
  logic            any_cold;
  xl_pick_t        pick;

  always_comb begin
    free_idx = '0;
    cold_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_idx = IDXW'(i);
      end
      if (!refd[i]) begin
        cold_idx = IDXW'(i);
      end
    end
  end

  assign any_free = ~&live;
  assign any_cold = ~&refd;

  always_comb begin
    if (dup_hit) begin
      pick = PICK_MATCH;
    end else if (any_free) begin
      pick = PICK_FREE;
    end else if (any_cold) begin
      pick = PICK_COLD;
    end else begin
      pick = PICK_WRAP;
    end
  end

  always_comb begin
    case (pick)
      PICK_MATCH: idx = dup_idx;
      PICK_FREE:  idx = free_idx;
      PICK_COLD:  idx = cold_idx;
      default:    idx = '0;
    endcase
  end

  assign clr_all = (pick == PICK_WRAP);
endmodule

// File: rtl/xl_tlb.sv
module xl_tlb
  import xl_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned IDXW     = $clog2(N_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_req,
  input  logic [XL_VA_W-1:0]  lk_vaddr,
  input  logic                lk_write,
  output logic                lk_hit,
  output logic [XL_PA_W-1:0]  lk_paddr,
  output logic                lk_fault,
  output logic                lk_dirty,
  input  logic                rf_req,
  input  logic [XL_VPN_W-1:0] rf_vpn,
  input  logic [XL_PPN_W-1:0] rf_ppn,
  input  logic                rf_rd_ok,
  input  logic                rf_wr_ok,
  input  logic                flush_all
);
  logic [N_ENTRIES-1:0]               live;
  logic [N_ENTRIES-1:0]               dirty;
  logic [N_ENTRIES-1:0]               refd;
  logic [N_ENTRIES-1:0][XL_VPN_W-1:0] tags;
  xl_map_t                            map_q [N_ENTRIES];

  logic                 lk_any;
  logic [N_ENTRIES-1:0] lk_vec;
  logic [IDXW-1:0]      lk_idx;
  logic                 rf_any;
  logic [N_ENTRIES-1:0] rf_vec;
  logic [IDXW-1:0]      rf_idx;
  logic [IDXW-1:0]      vic_idx;
  logic                 vic_clr;

  logic                 lk_match;
  logic                 lk_deny;
  logic                 lk_ok;
  logic                 rf_go;
  xl_map_t              hit_map;
  xl_map_t              new_map;

  // One slot per entry, each with its own status next-state logic
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    logic load_g;
    logic touch_g;
    assign load_g  = rf_go && (vic_idx == IDXW'(g));
    assign touch_g = lk_ok && lk_vec[g];

    xl_entry i_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_all),
      .load    (load_g),
      .clr_ref (rf_go && vic_clr),
      .touch   (touch_g),
      .wtouch  (touch_g && lk_write),
      .map_in  (new_map),
      .live_q  (live[g]),
      .dirty_q (dirty[g]),
      .refd_q  (refd[g]),
      .map_q   (map_q[g])
    );

    assign tags[g] = map_q[g].vpn;
  end

  xl_match #(.N(N_ENTRIES), .W(XL_VPN_W)) i_lk_match (
    .live  (live),
    .keys  (tags),
    .probe (lk_vaddr[XL_VA_W-1:XL_OFF_W]),
    .hit   (lk_any),
    .vec   (lk_vec),
    .idx   (lk_idx)
  );

  xl_match #(.N(N_ENTRIES), .W(XL_VPN_W)) i_rf_match (
    .live  (live),
    .keys  (tags),
    .probe (rf_vpn),
    .hit   (rf_any),
    .vec   (rf_vec),
    .idx   (rf_idx)
  );

  xl_victim #(.N(N_ENTRIES)) i_victim (
    .live    (live),
    .refd    (refd),
    .dup_hit (rf_any),
    .dup_idx (rf_idx),
    .idx     (vic_idx),
    .clr_all (vic_clr)
  );

  // Lookup path, purely combinational on the registered contents
  always_comb begin
    hit_map  = map_q[lk_idx];
    lk_match = lk_req && lk_any;
    lk_deny  = lk_write ? !hit_map.wr_ok : !hit_map.rd_ok;
    lk_ok    = lk_match && !lk_deny;
  end

  always_comb begin
    new_map.vpn   = rf_vpn;
    new_map.ppn   = rf_ppn;
    new_map.rd_ok = rf_rd_ok;
    new_map.wr_ok = rf_wr_ok;
  end

  assign rf_go = rf_req && !flush_all;

  assign lk_hit   = lk_match;
  assign lk_fault = lk_match && lk_deny;
  assign lk_dirty = lk_match && dirty[lk_idx];
  assign lk_paddr = lk_match ? {hit_map.ppn, lk_vaddr[XL_OFF_W-1:0]} : '0;

  AST_ONE_LK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec)); // R9
  AST_ONE_RF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rf_vec)); // R9
  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit); // R3
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && !lk_dirty && !lk_fault)); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[XL_OFF_W-1:0] == lk_vaddr[XL_OFF_W-1:0])); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit); // R10
  AST_REFILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && !flush_all) |=> (live != '0)); // R6
endmodule

// File: tb/test_xl_tlb.sv
`timescale 1ns/1ps
module test_xl_tlb;
  localparam int N = 64;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic        lk_write;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        lk_fault;
  logic        lk_dirty;
  logic        rf_req;
  logic [19:0] rf_vpn;
  logic [19:0] rf_ppn;
  logic        rf_rd_ok;
  logic        rf_wr_ok;
  logic        flush_all;

  int n_chk;
  int n_fail;

  // Bench model of the entries
  logic        m_v   [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_ppn [N];
  logic        m_rd  [N];
  logic        m_wr  [N];
  logic        m_d   [N];
  logic        m_r   [N];

  xl_tlb i_xl_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_vaddr  (lk_vaddr),
    .lk_write  (lk_write),
    .lk_hit    (lk_hit),
    .lk_paddr  (lk_paddr),
    .lk_fault  (lk_fault),
    .lk_dirty  (lk_dirty),
    .rf_req    (rf_req),
    .rf_vpn    (rf_vpn),
    .rf_ppn    (rf_ppn),
    .rf_rd_ok  (rf_rd_ok),
    .rf_wr_ok  (rf_wr_ok),
    .flush_all (flush_all)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int find_vpn(input logic [19:0] vpn);
    for (int j = 0; j < N; j++) begin
      if (m_v[j] && m_vpn[j] == vpn) return j;
    end
    return -1;
  endfunction

  // One cycle: drive, check combinational outputs, then apply the model update
  task automatic step(input string tag, input logic lq, input logic [31:0] va, input logic wr,
                      input logic rq, input logic [19:0] rv, input logic [19:0] rp,
                      input logic rr, input logic rw, input logic fl);
    int   li;
    int   vi;
    logic ok;
    logic clr;
    logic [31:0] e_pa;
    logic e_hit, e_flt, e_dty;
    @(negedge clk);
    lk_req = lq; lk_vaddr = va; lk_write = wr;
    rf_req = rq; rf_vpn = rv; rf_ppn = rp; rf_rd_ok = rr; rf_wr_ok = rw;
    flush_all = fl;
    #1;
    li    = lq ? find_vpn(va[31:12]) : -1;
    e_hit = (li >= 0);
    e_flt = e_hit && (wr ? !m_wr[li] : !m_rd[li]);
    e_dty = e_hit && m_d[li];
    e_pa  = e_hit ? {m_ppn[li], va[11:0]} : 32'h0;
    ok    = e_hit && !e_flt;
    check({tag, " hit"},   {31'h0, lk_hit},   {31'h0, e_hit});
    check({tag, " paddr"}, lk_paddr,          e_pa);
    check({tag, " fault"}, {31'h0, lk_fault}, {31'h0, e_flt});
    check({tag, " dirty"}, {31'h0, lk_dirty}, {31'h0, e_dty});
    // victim from the old contents
    clr = 1'b0;
    vi  = find_vpn(rv);
    if (vi < 0) begin
      for (int j = N - 1; j >= 0; j--) if (!m_v[j]) vi = j;
    end
    if (vi < 0) begin
      for (int j = N - 1; j >= 0; j--) if (!m_r[j]) vi = j;
    end
    if (vi < 0) begin
      vi  = 0;
      clr = 1'b1;
    end
    @(posedge clk);
    for (int j = 0; j < N; j++) begin
      if (fl) begin
        m_v[j] = 1'b0; m_d[j] = 1'b0; m_r[j] = 1'b0;
      end else if (rq && j == vi) begin
        m_v[j] = 1'b1; m_d[j] = 1'b0; m_r[j] = 1'b0;
        m_vpn[j] = rv; m_ppn[j] = rp; m_rd[j] = rr; m_wr[j] = rw;
      end else begin
        if (rq && clr) m_r[j] = 1'b0;
        if (ok && j == li) begin
          m_r[j] = 1'b1;
          if (wr) m_d[j] = 1'b1;
        end
      end
    end
  endtask

  task automatic look(input string tag, input logic [19:0] vpn, input logic wr);
    step(tag, 1'b1, {vpn, 12'(vpn * 7)}, wr, 1'b0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic fill(input string tag, input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic rd, input logic wr);
    step(tag, 1'b0, 32'h0, 1'b0, 1'b1, vpn, ppn, rd, wr, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    n_chk = 0; n_fail = 0;
    for (int j = 0; j < N; j++) begin
      m_v[j] = 0; m_d[j] = 0; m_r[j] = 0; m_vpn[j] = 0; m_ppn[j] = 0; m_rd[j] = 0; m_wr[j] = 0;
    end
    rst_n = 1'b0;
    lk_req = 0; lk_vaddr = 0; lk_write = 0;
    rf_req = 0; rf_vpn = 0; rf_ppn = 0; rf_rd_ok = 0; rf_wr_ok = 0; flush_all = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R12: empty after reset
    look("R12", 20'd100, 1'b0);
    // R6: fill all slots in order, odd slots writable
    for (int i = 0; i < N; i++) fill("R6", 20'(100 + i), 20'(200 + i), 1'b1, 1'(i % 2));
    // R1: every mapping hits with its page number
    for (int i = 0; i < N; i++) look("R1", 20'(100 + i), 1'b0);
    // R4: write to a writable slot sets dirty, seen on the next lookup
    look("R4", 20'd101, 1'b1);
    look("R4", 20'd101, 1'b0);
    // R3: write to a read-only slot faults, dirty stays clear
    look("R3", 20'd100, 1'b1);
    look("R3", 20'd100, 1'b0);
    // R8: every reference bit set -> slot 0 replaced and references cleared
    fill("R8", 20'd500, 20'd900, 1'b1, 1'b1);
    look("R8", 20'd100, 1'b0);
    look("R8", 20'd500, 1'b0);
    look("R5", 20'd102, 1'b0);
    // R7: lowest cold slot is slot 1 (slot 0 and 2 referenced again)
    fill("R7", 20'd501, 20'd901, 1'b1, 1'b0);
    look("R7", 20'd101, 1'b0);
    look("R5", 20'd102, 1'b0);
    look("R7", 20'd501, 1'b0);
    // R9: refill of a present page overwrites it
    look("R9", 20'd103, 1'b1);
    fill("R9", 20'd103, 20'hABCDE, 1'b1, 1'b1);
    look("R9", 20'd103, 1'b0);
    // R11: lookup and refill of the same page in one cycle
    step("R11", 1'b1, {20'd600, 12'h321}, 1'b0, 1'b1, 20'd600, 20'd777, 1'b1, 1'b1, 1'b0);
    look("R11", 20'd600, 1'b0);
    step("R11", 1'b1, {20'd104, 12'h055}, 1'b1, 1'b1, 20'd104, 20'd778, 1'b1, 1'b1, 1'b0);
    look("R11", 20'd104, 1'b0);
    // R10: flush beats a same-cycle refill
    step("R10", 1'b0, 32'h0, 1'b0, 1'b1, 20'd700, 20'd701, 1'b1, 1'b1, 1'b1);
    look("R10", 20'd700, 1'b0);
    look("R10", 20'd105, 1'b0);

    // R2: random traffic over a small page pool with collisions
    seed = 32'd1234;
    void'($urandom(seed));
    for (int c = 0; c < 6000; c++) begin
      logic [19:0] lv, rv;
      lv = 20'($urandom_range(0, 90));
      rv = 20'($urandom_range(0, 90));
      step("R2", 1'($urandom_range(0, 3) != 0), {lv, 12'($urandom)}, 1'($urandom),
           1'($urandom_range(0, 2) == 0), rv, 20'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom_range(0, 700) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule